// File: doc/BRIEF.md
# Shared Micro-op Queue with Loop Replay

This block is a micro-op buffer between the front-end and rename. Micro-ops come from either of two sources, the legacy decoders or the micro-op cache. Each one arrives with a one-bit tag that names its source, and the tag travels with the micro-op to the output. The storage serves two hardware threads. In single-thread mode thread 0 owns every entry. In dual-thread mode the storage is split into two fixed halves, one per thread. A change of partition mode is held back until the queue has drained.

The same storage also works as a loop cache. Each micro-op can carry a flag that marks it as a taken backward branch, together with the loop body length counted in micro-ops, branch included. If that whole body is still in the thread's region, and it fits, the thread enters replay. It stops accepting new micro-ops and sends the captured body over and over without refetching. Replay ends only when that thread is flushed. A flush empties only that thread's region.

Each cycle the queue sends up to four micro-ops from one thread. In dual-thread mode it alternates between the threads, and a thread with nothing to send is skipped.

Top module: `shared_uop_queue`

## Requirements
- R1: After reset the queue is in single-thread mode and empty: all `outValid` bits are 0, and `inReady` is 1 for thread 0 and 0 for thread 1.
- R2: Within a thread, micro-ops leave in the order they were accepted. Each one keeps its payload and its source tag (`outSrc` 0 = decoders, 1 = micro-op cache).
- R3: In single-thread mode thread 0 can hold 56 micro-ops. `inReady` for thread 0 drops when 56 are held, and thread 1 is never accepted.
- R4: In dual-thread mode each thread holds at most 28 micro-ops. A full thread does not lower `inReady` for the other thread.
- R5: A request on `dualReq` for a different mode takes effect only once both regions are empty and no replay is active. While the request waits, `inReady` is 0 for both threads.
- R6: Each cycle the queue presents min(held, 4) micro-ops of the selected thread, oldest in slot 0, with `outValid` a contiguous run from bit 0. All presented micro-ops are consumed on a cycle with `outReady` high.
- R7: In dual-thread mode the output thread alternates on each consuming cycle when both threads hold micro-ops. A thread with nothing to send is skipped. The first choice after reset is thread 0.
- R8: An accepted micro-op with `inLoopBr`=1 and body length L starts replay if three conditions hold: 1 ≤ L, L−1 ≤ micro-ops written to the thread since its last flush or mode change, and L ≤ the region size. The thread then refuses input, and its output cycles through the L most recent micro-ops without end, the branch being last in each pass.
- R9: A loop branch whose body length is 0, exceeds the written history, or exceeds the region size is queued as an ordinary micro-op, and no replay starts.
- R10: `flushThr[t]` empties thread t's region and ends its replay. The other thread's contents are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Micro-op offered |
| inThread | input | 1 | Thread of offered micro-op |
| inUop | input | UOP_W | Micro-op payload |
| inSrc | input | 1 | Source tag: 0 decoders, 1 micro-op cache |
| inLoopBr | input | 1 | Micro-op is a taken backward branch |
| inLoopLen | input | 6 | Loop body length including the branch |
| inReady | output | 1 | Offered micro-op is accepted this cycle |
| dualReq | input | 1 | Requested mode: 1 two threads, 0 one thread |
| flushThr | input | 2 | Per-thread flush |
| outReady | input | 1 | Rename consumes all presented micro-ops |
| outValid | output | 4 | Valid mask of output slots |
| outThread | output | 1 | Thread of the presented micro-ops |
| outUop | output | 4*UOP_W | Output payloads, slot k at bits k*UOP_W |
| outSrc | output | 4 | Source tag per output slot |

## Verification
The hardest state to reach is a replay whose body is shorter than the four-wide output. In that state the read walk wraps from the branch back to the loop start within a single cycle, and the head pointer must land in the middle of the body after a pop. The bench builds a three-entry loop in dual-thread mode and checks the slots across two consecutive presentations. It then loads the other thread, flushes the looping thread, and shows that only the other thread's micro-ops remain. A pending mode change is held by keeping `outReady` low after the request, so the wait state can be observed.

// File: rtl/uq_pkg.sv
package uq_pkg;
  localparam int unsigned QDEPTH = 56;
  localparam int unsigned QHALF  = QDEPTH / 2;
  localparam int unsigned DEQ_W  = 4;
  localparam int unsigned IDX_W  = $clog2(QDEPTH);
  localparam int unsigned CNT_W  = $clog2(QDEPTH + 1);
  localparam int unsigned SEL_W  = $clog2(DEQ_W + 1);

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic                  wrEn;
    idx_t                  wrIdx;
    idx_t [DEQ_W-1:0]      rdIdx;
  } uq_strobe_t;
endpackage

// File: rtl/uq_ctrl.sv
module uq_ctrl
  import uq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inThread,
  input  logic             inLoopBr,
  input  cnt_t             inLoopLen,
  input  logic             dualReq,
  input  logic [1:0]       flushThr,
  input  logic             outReady,
  output logic             inReady,
  output logic [DEQ_W-1:0] outValid,
  output logic             outThread,
  output uq_strobe_t       strobe
);
  logic dual, lastThr;
  idx_t head [2];
  idx_t tail [2];
  cnt_t cnt [2];
  cnt_t hist [2];
  logic replay [2];
  idx_t lpStart [2];
  idx_t lpEnd [2];

  function automatic idx_t baseOf(input logic d, input logic t);
    return (d && t) ? idx_t'(QHALF) : '0;
  endfunction

  function automatic cnt_t capOf(input logic d);
    return d ? cnt_t'(QHALF) : cnt_t'(QDEPTH);
  endfunction

  function automatic idx_t stepIdx(input idx_t i, input logic d, input logic t);
    idx_t lastI;
    lastI = baseOf(d, t) + idx_t'(capOf(d) - cnt_t'(1));
    return (i == lastI) ? baseOf(d, t) : i + idx_t'(1);
  endfunction

  logic             modePend, modeSwitch, sel, pushOk, capture;
  logic [1:0]       has;
  logic [SEL_W-1:0] avail, popN;
  idx_t             walk [DEQ_W+1];
  idx_t             startIdx;
  logic [CNT_W:0]   offs, pos;

  always_comb begin
    modePend   = (dualReq != dual);
    has[0]     = replay[0] || (cnt[0] != '0);
    has[1]     = replay[1] || (cnt[1] != '0);
    modeSwitch = modePend && !has[0] && !has[1];
    sel        = !dual ? 1'b0 : (has[~lastThr] ? ~lastThr : lastThr);
    if (replay[sel])                      avail = SEL_W'(DEQ_W);
    else if (cnt[sel] >= cnt_t'(DEQ_W))   avail = SEL_W'(DEQ_W);
    else                                  avail = cnt[sel][SEL_W-1:0];
    walk[0] = head[sel];
    for (int k = 1; k <= DEQ_W; k++)
      walk[k] = (replay[sel] && walk[k-1] == lpEnd[sel]) ? lpStart[sel]
                                                       : stepIdx(walk[k-1], dual, sel);
    for (int k = 0; k < DEQ_W; k++)
      outValid[k] = (k < int'(avail));
    popN      = outReady ? avail : '0;
    outThread = sel;

    inReady = (!inThread || dual) && !modePend && (cnt[inThread] < capOf(dual))
              && !replay[inThread] && !flushThr[inThread];
    pushOk  = inValid && inReady;
    capture = pushOk && inLoopBr && (inLoopLen != '0)
              && ({1'b0, inLoopLen} <= {1'b0, hist[inThread]} + 1'b1)
              && (inLoopLen <= capOf(dual));
    offs = {1'b0, tail[inThread]} - {1'b0, baseOf(dual, inThread)};
    pos  = offs + {1'b0, capOf(dual)} - ({1'b0, inLoopLen} - 1'b1);
    if (pos >= {1'b0, capOf(dual)}) pos = pos - {1'b0, capOf(dual)};
    startIdx = baseOf(dual, inThread) + pos[IDX_W-1:0];

    strobe.wrEn  = pushOk;
    strobe.wrIdx = tail[inThread];
    for (int k = 0; k < DEQ_W; k++) strobe.rdIdx[k] = walk[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dual    <= 1'b0;
      lastThr <= 1'b1;
      for (int t = 0; t < 2; t++) begin
        head[t]    <= '0;
        tail[t]    <= '0;
        cnt[t]     <= '0;
        hist[t]    <= '0;
        replay[t]  <= 1'b0;
        lpStart[t] <= '0;
        lpEnd[t]   <= '0;
      end
    end else begin
      if (modeSwitch) dual <= dualReq;
      if (dual && popN != '0) lastThr <= sel;
      for (int t = 0; t < 2; t++) begin
        logic pushT, popT;
        pushT = pushOk && (inThread == 1'(t));
        popT  = (sel == 1'(t)) && (popN != '0);
        if (modeSwitch || flushThr[t]) begin
          head[t]   <= baseOf(modeSwitch ? dualReq : dual, 1'(t));
          tail[t]   <= baseOf(modeSwitch ? dualReq : dual, 1'(t));
          cnt[t]    <= '0;
          hist[t]   <= '0;
          replay[t] <= 1'b0;
        end else begin
          if (pushT) begin
            tail[t] <= stepIdx(tail[t], dual, 1'(t));
            if (hist[t] < capOf(dual)) hist[t] <= hist[t] + cnt_t'(1);
            if (capture) begin
              replay[t]  <= 1'b1;
              lpEnd[t]   <= tail[t];
              lpStart[t] <= startIdx;
            end
          end
          if (popT) head[t] <= walk[popN];
          cnt[t] <= cnt[t] + cnt_t'(pushT)
                    - ((popT && !replay[t]) ? cnt_t'(popN) : '0);
        end
      end
    end
  end

  for (genvar gi = 0; gi < 2; gi++) begin : g_chk
    AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
      cnt[gi] <= capOf(dual)); // R4
    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      flushThr[gi] |=> (cnt[gi] == '0) && !replay[gi]); // R10
    AST_REPLAY_NO_FILL: assert property (@(posedge clk) disable iff (!rstN)
      (replay[gi] && !flushThr[gi]) |=> tail[gi] == $past(tail[gi])); // R8
  end

  AST_MODE_DRAINED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dual) |-> ($past(cnt[0]) == '0) && ($past(cnt[1]) == '0)); // R5
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    !dual |-> (cnt[1] == '0) && !replay[1]); // R3
endmodule

// File: rtl/uq_data.sv
module uq_data
  import uq_pkg::*;
#(
  parameter int unsigned UOP_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  uq_strobe_t             strobe,
  input  logic [UOP_W-1:0]       inUop,
  input  logic                   inSrc,
  output logic [DEQ_W*UOP_W-1:0] outUop,
  output logic [DEQ_W-1:0]       outSrc
);
  logic [UOP_W:0] mem [QDEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[strobe.wrIdx] <= {inSrc, inUop};
  end

  for (genvar k = 0; k < DEQ_W; k++) begin : g_rd
    assign outUop[k*UOP_W +: UOP_W] = mem[strobe.rdIdx[k]][UOP_W-1:0];
    assign outSrc[k]                = mem[strobe.rdIdx[k]][UOP_W];
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (int'(strobe.wrIdx) < QDEPTH)); // R2
endmodule

// File: rtl/shared_uop_queue.sv
module shared_uop_queue
  import uq_pkg::*;
#(
  parameter int unsigned UOP_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   inThread,
  input  logic [UOP_W-1:0]       inUop,
  input  logic                   inSrc,
  input  logic                   inLoopBr,
  input  logic [CNT_W-1:0]       inLoopLen,
  output logic                   inReady,
  input  logic                   dualReq,
  input  logic [1:0]             flushThr,
  input  logic                   outReady,
  output logic [DEQ_W-1:0]       outValid,
  output logic                   outThread,
  output logic [DEQ_W*UOP_W-1:0] outUop,
  output logic [DEQ_W-1:0]       outSrc
);
  uq_strobe_t strobe;

  uq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inThread(inThread),
    .inLoopBr(inLoopBr), .inLoopLen(inLoopLen), .dualReq(dualReq),
    .flushThr(flushThr), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .outThread(outThread), .strobe(strobe)
  );

  uq_data #(.UOP_W(UOP_W)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inUop(inUop), .inSrc(inSrc),
    .outUop(outUop), .outSrc(outSrc)
  );
endmodule

// File: tb/shared_uop_queue_tb_top.sv
`timescale 1ns/1ps
module shared_uop_queue_tb_top;
  localparam int UW = 16;
  logic clk = 0, rstN = 0;
  logic inValid = 0, inThread = 0, inSrc = 0, inLoopBr = 0;
  logic [UW-1:0] inUop = '0;
  logic [5:0] inLoopLen = '0;
  logic inReady, dualReq = 0, outReady = 0, outThread;
  logic [1:0] flushThr = '0;
  logic [3:0] outValid, outSrc;
  logic [4*UW-1:0] outUop;

  shared_uop_queue #(.UOP_W(UW)) dut_i (.*);

  always #2 clk = ~clk;

  int nChk = 0, nErr = 0;
  bit sbOn = 0;
  logic [UW:0] q0[$], q1[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [UW-1:0] slot(input int k);
    return outUop[k*UW +: UW];
  endfunction

  task automatic pushU(input bit thr, input int d, input bit src, input bit br,
                       input int len, input bit track, output bit acc);
    inValid = 1; inThread = thr; inUop = UW'(d); inSrc = src;
    inLoopBr = br; inLoopLen = 6'(len);
    @(negedge clk); acc = inReady;
    @(posedge clk); #1;
    inValid = 0; inLoopBr = 0;
    if (acc && track) begin
      if (thr) q1.push_back({src, UW'(d)}); else q0.push_back({src, UW'(d)});
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (sbOn && outReady) begin
      for (int k = 0; k < 4; k++) begin
        if (outValid[k]) begin
          logic [UW:0] got, exp;
          got = {outSrc[k], slot(k)};
          if (outThread ? q1.size() == 0 : q0.size() == 0)
            chk(0, "R2 unexpected output", int'(got), 0);
          else begin
            exp = outThread ? q1.pop_front() : q0.pop_front();
            chk(got == exp, "R2 order/payload/source", int'(got), int'(exp));
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    chk(0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    bit acc;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    @(negedge clk);
    chk(outValid == 4'b0, "R1 outValid", outValid, 0);
    chk(inReady == 1'b1, "R1 thread0 ready", inReady, 1);
    @(posedge clk); #1 inThread = 1;
    @(negedge clk);
    chk(inReady == 1'b0, "R1 thread1 not ready", inReady, 0);
    @(posedge clk); #1;

    // R3 fill thread 0 with 56, mixed sources
    for (int i = 0; i < 56; i++) begin
      pushU(0, 16'h0100 + i, i[0], 0, 0, 1, acc);
      if (!acc) chk(0, "R3 accept", 0, 1);
    end
    inThread = 0;
    @(negedge clk);
    chk(inReady == 1'b0, "R3 full at 56", inReady, 0);
    chk(outValid == 4'hF, "R6 four slots", outValid, 15);
    @(posedge clk); #1 inThread = 1;
    @(negedge clk);
    chk(inReady == 1'b0, "R3 thread1 refused", inReady, 0);
    @(posedge clk); #1;
    sbOn = 1; outReady = 1;
    while (q0.size() != 0) @(posedge clk);
    #1 outReady = 0;
    @(negedge clk);
    chk(outValid == 4'b0, "R2 drained", outValid, 0);
    @(posedge clk); #1;

    // R6 partial presentation
    pushU(0, 16'h0200, 1, 0, 0, 1, acc);
    pushU(0, 16'h0201, 0, 0, 0, 1, acc);
    @(negedge clk);
    chk(outValid == 4'b0011, "R6 two slots", outValid, 3);
    @(posedge clk); #1;
    outReady = 1;
    while (q0.size() != 0) @(posedge clk);
    #1 outReady = 0;

    // R5 pending mode change
    for (int i = 0; i < 3; i++) pushU(0, 16'h0300 + i, 0, 0, 0, 1, acc);
    dualReq = 1; inThread = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(inReady == 1'b0, "R5 blocked while pending", inReady, 0);
    @(posedge clk); #1 outReady = 1;
    while (q0.size() != 0) @(posedge clk);
    #1 outReady = 0;
    repeat (3) @(posedge clk);
    #1 inThread = 1;
    @(negedge clk);
    chk(inReady == 1'b1, "R5 dual mode active", inReady, 1);
    @(posedge clk); #1;

    // R4 halves
    for (int i = 0; i < 28; i++) pushU(1, 16'h1400 + i, 1, 0, 0, 1, acc);
    inThread = 1;
    @(negedge clk);
    chk(inReady == 1'b0, "R4 thread1 full at 28", inReady, 0);
    @(posedge clk); #1 inThread = 0;
    @(negedge clk);
    chk(inReady == 1'b1, "R4 thread0 unaffected", inReady, 1);
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) pushU(0, 16'h0500 + i, 0, 0, 0, 1, acc);

    // R7 round robin with skip
    outReady = 1;
    begin
      int expThr[6] = '{0, 1, 0, 1, 1, 1};
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        chk(outThread == 1'(expThr[c]), "R7 thread order", outThread, expThr[c]);
        if (c == 2) chk(outValid == 4'b0001, "R7 last thread0 slot", outValid, 1);
      end
    end
    while (q1.size() != 0) @(posedge clk);
    #1 outReady = 0; sbOn = 0;

    // R8 loop capture, body of 3 shorter than output width
    pushU(0, 16'h0B00, 0, 0, 0, 0, acc);
    pushU(0, 16'h0B01, 1, 0, 0, 0, acc);
    pushU(0, 16'h0B02, 0, 1, 3, 0, acc);
    inThread = 0;
    @(negedge clk);
    chk(inReady == 1'b0, "R8 input refused in replay", inReady, 0);
    chk(outValid == 4'hF && outThread == 1'b0, "R8 replay slots", outValid, 15);
    chk(slot(0) == 16'h0B00 && slot(3) == 16'h0B00, "R8 wrap in slots", slot(3), 16'h0B00);
    chk(slot(2) == 16'h0B02 && outSrc[1] == 1'b1, "R8 branch last", slot(2), 16'h0B02);
    @(posedge clk); #1 outReady = 1;
    @(posedge clk); #1 outReady = 0;
    @(negedge clk);
    chk(slot(0) == 16'h0B01 && slot(1) == 16'h0B02, "R8 second pass", slot(0), 16'h0B01);
    chk(slot(2) == 16'h0B00 && slot(3) == 16'h0B01, "R8 second pass tail", slot(3), 16'h0B01);
    @(posedge clk); #1;

    // R10 flush isolation
    pushU(1, 16'h1D00, 0, 0, 0, 0, acc);
    pushU(1, 16'h1D01, 1, 0, 0, 0, acc);
    flushThr = 2'b01;
    @(posedge clk); #1 flushThr = 2'b00; inThread = 0;
    @(negedge clk);
    chk(inReady == 1'b1, "R10 replay ended", inReady, 1);
    chk(outThread == 1'b1 && outValid == 4'b0011, "R10 other thread kept", outValid, 3);
    chk(slot(0) == 16'h1D00 && slot(1) == 16'h1D01, "R10 other contents", slot(1), 16'h1D01);
    @(posedge clk); #1 outReady = 1;
    @(posedge clk); #1 outReady = 0;
    @(negedge clk);
    chk(outValid == 4'b0, "R10 flushed region empty", outValid, 0);
    @(posedge clk); #1;

    // R9 loop too long for history: queued as normal
    sbOn = 1;
    pushU(0, 16'h0C00, 0, 0, 0, 1, acc);
    pushU(0, 16'h0C01, 1, 0, 0, 1, acc);
    pushU(0, 16'h0C02, 0, 1, 5, 1, acc);
    inThread = 0;
    @(negedge clk);
    chk(inReady == 1'b1, "R9 no replay started", inReady, 1);
    @(posedge clk); #1 outReady = 1;
    while (q0.size() != 0) @(posedge clk);
    #1 outReady = 0;
    @(negedge clk);
    chk(outValid == 4'b0, "R9 no repeat", outValid, 0);
    chk(q0.size() == 0 && q1.size() == 0, "R2 scoreboard empty", q0.size() + q1.size(), 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule